// File: doc/BRIEF.md
# Immediate-Operand Integer Execution Stage

This block carries out the register-immediate integer operations of a 32-bit load/store processor. Each cycle it receives one 32-bit instruction word together with the value already read from the first source register. It picks out the opcode, the destination register index and the 16-bit immediate. It widens the immediate in the way the opcode requires and computes the result in a single combinational pass. A register stage then holds the result, the destination index, a write-enable and an overflow flag, ready for the register file's write port.

Five operations are supported: load the upper half with a constant, bitwise OR with a constant, add a constant while ignoring overflow, add a constant with signed overflow detection, and unsigned compare against a constant. Loading the upper half and then ORing in the lower half builds any 32-bit constant in two instructions. Any other opcode produces no register write.

Top module: `imm_exec_unit`

## Requirements
- R1: The instruction word is decoded as opcode = bits 31:26, source index = bits 25:21, destination index = bits 20:16 and immediate = bits 15:0; `dst_idx_o` reports bits 20:16.
- R2: Opcode 0x0F (load upper) produces {imm, 16'h0000} and asserts write-enable.
- R3: Opcode 0x0D (OR) zero-extends the immediate, so the result is rs OR {16'h0000, imm}, and bits 31:16 equal those of rs.
- R4: Opcode 0x09 (add, overflow ignored) sign-extends the immediate, adds it modulo 2^32, and never raises the overflow flag.
- R5: Opcode 0x08 (signed add) sign-extends the immediate. When both operands have the same sign and the sum's sign differs, it raises the overflow flag and drops write-enable. Otherwise it writes the sum.
- R6: Opcode 0x0B (unsigned compare) sign-extends the immediate, then compares rs with it as unsigned 32-bit numbers; the result is 1 when rs is lower, else 0.
- R7: Any opcode other than 0x0F, 0x0D, 0x09, 0x08 or 0x0B gives write-enable 0, overflow 0 and result 0.
- R8: All outputs are registered and change on the rising clock edge after the inputs are applied. An active-low asynchronous reset clears every output to 0.
- R9: A load upper of 0xABAB, followed by an OR of 0xCDCD whose source is that result, yields 0xABABCDCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the source register |
| result_o | output | 32 | Registered operation result |
| dst_idx_o | output | 5 | Registered destination register index |
| wr_en_o | output | 1 | Registered register write-enable |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
On every cycle the assertions check the following: overflow never coexists with a write; the load-upper result has a clear lower half carrying the previous immediate; the OR result keeps the upper half of rs; the compare result is a single bit; and an unknown opcode never writes. The bench scenarios show the arithmetic corners that assertions cannot capture without copying the adder. These are wrap-around of the overflow-ignoring add, positive and negative signed overflow, and the compare against an immediate sign-extended to a huge unsigned value. They also show the two-instruction constant build and the asynchronous clear.

// File: rtl/imm_pkg.sv
package imm_pkg;
  localparam int DATA_W = 32;
  localparam int OP_W   = 6;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 16;

  typedef enum logic [OP_W-1:0] {
    OP_ADDS  = 6'h08,
    OP_ADDW  = 6'h09,
    OP_CMPU  = 6'h0B,
    OP_ORL   = 6'h0D,
    OP_LDHI  = 6'h0F
  } op_e;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op == OP_ADDS) || (op == OP_ADDW) || (op == OP_CMPU) ||
           (op == OP_ORL)  || (op == OP_LDHI);
  endfunction
endpackage

// File: rtl/imm_extend.sv
module imm_extend
  import imm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IMM_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [IW-1:0]   imm_i,
  output logic [DW-1:0]   ext_o
);
  localparam int PAD = DW - IW;

  always_comb begin
    unique case (op_i)
      OP_ORL:  ext_o = {{PAD{1'b0}}, imm_i};
      OP_LDHI: ext_o = {imm_i, {PAD{1'b0}}};
      default: ext_o = {{PAD{imm_i[IW-1]}}, imm_i};
    endcase
  end
endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import imm_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   res_o,
  output logic            we_o,
  output logic            ovf_o
);
  logic [DW-1:0] sum;
  logic          sgn_ovf;

  assign sum     = a_i + b_i;
  assign sgn_ovf = (a_i[DW-1] == b_i[DW-1]) && (sum[DW-1] != a_i[DW-1]);

  always_comb begin
    res_o = '0;
    we_o  = 1'b1;
    ovf_o = 1'b0;
    case (op_i)
      OP_LDHI: res_o = b_i;
      OP_ORL:  res_o = a_i | b_i;
      OP_ADDW: res_o = sum;
      OP_ADDS: begin
        res_o = sum;
        ovf_o = sgn_ovf;
        we_o  = !sgn_ovf;
      end
      OP_CMPU: res_o = {{(DW-1){1'b0}}, (a_i < b_i)};
      default: we_o = 1'b0;
    endcase
  end

  always_comb begin
    if (ovf_o) assert (!we_o) else $error("AST_ALU_OVF_WE"); // R5
  end
endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
  import imm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int RW = REG_W,
  parameter int IW = IMM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] instr_i,
  input  logic [DW-1:0] rs_val_i,
  output logic [DW-1:0] result_o,
  output logic [RW-1:0] dst_idx_o,
  output logic          wr_en_o,
  output logic          ovf_o
);
  localparam int OP_LSB  = DW - OP_W;
  localparam int SRC_LSB = OP_LSB - RW;
  localparam int DST_LSB = SRC_LSB - RW;

  logic [OP_W-1:0] op;
  logic [RW-1:0]   dst_idx;
  logic [IW-1:0]   imm;
  logic [RW-1:0]   unused_src_idx;
  logic [DW-1:0]   imm_ext;
  logic [DW-1:0]   res_d;
  logic            we_d;
  logic            ovf_d;

  assign op             = instr_i[DW-1 -: OP_W];
  assign unused_src_idx = instr_i[SRC_LSB +: RW];
  assign dst_idx        = instr_i[DST_LSB +: RW];
  assign imm            = instr_i[IW-1:0];

  imm_extend #(.DW(DW), .IW(IW)) u_ext (
    .op_i  (op),
    .imm_i (imm),
    .ext_o (imm_ext)
  );

  imm_alu #(.DW(DW)) u_alu (
    .op_i  (op),
    .a_i   (rs_val_i),
    .b_i   (imm_ext),
    .res_o (res_d),
    .we_o  (we_d),
    .ovf_o (ovf_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o  <= '0;
      dst_idx_o <= '0;
      wr_en_o   <= 1'b0;
      ovf_o     <= 1'b0;
    end else begin
      result_o  <= res_d;
      dst_idx_o <= dst_idx;
      wr_en_o   <= we_d;
      ovf_o     <= ovf_d;
    end
  end

  AST_NO_WRITE_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> !wr_en_o); // R5
  AST_LDHI_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(instr_i[DW-1 -: OP_W]) == OP_LDHI) |->
    (result_o == {$past(instr_i[IW-1:0]), {(DW-IW){1'b0}}})); // R2
  AST_ORL_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(instr_i[DW-1 -: OP_W]) == OP_ORL) |->
    (result_o[DW-1:IW] == $past(rs_val_i[DW-1:IW]))); // R3
  AST_ADDW_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(instr_i[DW-1 -: OP_W]) == OP_ADDW) |-> !ovf_o); // R4
  AST_CMPU_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(instr_i[DW-1 -: OP_W]) == OP_CMPU) |->
    (result_o[DW-1:1] == '0)); // R6
  AST_UNKNOWN_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_known(op) |=> (!wr_en_o && !ovf_o)); // R7
  AST_DST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (dst_idx_o == $past(instr_i[DST_LSB +: RW]))); // R1
endmodule

// File: tb/test_imm_exec_unit.sv
module test_imm_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] result_o;
  logic [4:0]  dst_idx_o;
  logic        wr_en_o;
  logic        ovf_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  imm_exec_unit i_imm_exec_unit (
    .clk, .rst_n, .instr_i, .rs_val_i, .result_o, .dst_idx_o, .wr_en_o, .ovf_o
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [31:0] rsv);
    @(negedge clk);
    instr_i  = ins;
    rs_val_i = rsv;
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    chk("R8 reset result", result_o, 0);
    chk("R8 reset we", {31'b0, wr_en_o}, 0);
    chk("R8 reset ovf", {31'b0, ovf_o}, 0);
    chk("R8 reset dst", {27'b0, dst_idx_o}, 0);
  endtask

  task automatic t_ldhi();
    issue(mk(6'h0F, 5'd3, 5'd17, 16'h1234), 32'hFFFF_FFFF);
    chk("R2 ldhi result", result_o, 32'h1234_0000);
    chk("R2 ldhi we", {31'b0, wr_en_o}, 1);
    chk("R1 dst index", {27'b0, dst_idx_o}, 17);
  endtask

  task automatic t_orl();
    issue(mk(6'h0D, 5'd1, 5'd2, 16'h8001), 32'h1234_0000);
    chk("R3 or zero-extend", result_o, 32'h1234_8001);
  endtask

  task automatic t_addw();
    issue(mk(6'h09, 5'd1, 5'd4, 16'h0001), 32'h7FFF_FFFF);
    chk("R4 addw wrap", result_o, 32'h8000_0000);
    chk("R4 addw no ovf", {31'b0, ovf_o}, 0);
    chk("R4 addw we", {31'b0, wr_en_o}, 1);
    issue(mk(6'h09, 5'd1, 5'd4, 16'hFFFF), 32'd5);
    chk("R4 addw sign-extend", result_o, 32'd4);
  endtask

  task automatic t_adds();
    issue(mk(6'h08, 5'd1, 5'd5, 16'hFFFE), 32'd10);
    chk("R5 adds sum", result_o, 32'd8);
    chk("R5 adds we", {31'b0, wr_en_o}, 1);
    issue(mk(6'h08, 5'd1, 5'd5, 16'h0001), 32'h7FFF_FFFF);
    chk("R5 pos ovf flag", {31'b0, ovf_o}, 1);
    chk("R5 pos ovf we", {31'b0, wr_en_o}, 0);
    issue(mk(6'h08, 5'd1, 5'd5, 16'hFFFF), 32'h8000_0000);
    chk("R5 neg ovf flag", {31'b0, ovf_o}, 1);
    chk("R5 neg ovf we", {31'b0, wr_en_o}, 0);
  endtask

  task automatic t_cmpu();
    issue(mk(6'h0B, 5'd1, 5'd6, 16'hFFFF), 32'd5);
    chk("R6 cmpu below big", result_o, 1);
    issue(mk(6'h0B, 5'd1, 5'd6, 16'hFFFF), 32'hFFFF_FFFF);
    chk("R6 cmpu equal", result_o, 0);
    issue(mk(6'h0B, 5'd1, 5'd6, 16'h0001), 32'h8000_0000);
    chk("R6 cmpu unsigned", result_o, 0);
    issue(mk(6'h0B, 5'd1, 5'd6, 16'h0004), 32'd3);
    chk("R6 cmpu less", result_o, 1);
  endtask

  task automatic t_unknown();
    issue(mk(6'h0C, 5'd1, 5'd7, 16'hFFFF), 32'h7FFF_FFFF);
    chk("R7 unknown we", {31'b0, wr_en_o}, 0);
    chk("R7 unknown result", result_o, 0);
    chk("R7 unknown ovf", {31'b0, ovf_o}, 0);
  endtask

  task automatic t_build();
    logic [31:0] hi;
    issue(mk(6'h0F, 5'd0, 5'd8, 16'hABAB), 32'h0);
    hi = result_o;
    issue(mk(6'h0D, 5'd8, 5'd8, 16'hCDCD), hi);
    chk("R9 constant build", result_o, 32'hABAB_CDCD);
  endtask

  task automatic t_async_clear();
    issue(mk(6'h0F, 5'd0, 5'd9, 16'h5555), 32'h0);
    #1 rst_n = 1'b0;
    #1;
    chk("R8 async clear result", result_o, 0);
    chk("R8 async clear we", {31'b0, wr_en_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2 t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_ldhi();
    t_orl();
    t_addw();
    t_adds();
    t_cmpu();
    t_unknown();
    t_build();
    t_async_clear();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule